// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This unit turns one half-, single- or double-precision floating-point operand into an unsigned or signed integer that is 16, 32 or 64 bits wide. Each request carries a 64-bit source word and a small set of controls. The source format selects the operand, and the destination code selects the width and signedness. The other controls pick one of four rounding modes, enable flushing of single-precision denormals, and choose which 16-bit half of the word holds a half-precision operand.

The result appears one clock after the request, on a 64-bit bus, together with a flag that rejects unsupported format pairs and three condition flags. Values that fall outside the destination range are clamped to the nearest limit. NaN inputs give fixed patterns, and those patterns depend on both the source and the destination format. Narrow results are zero-extended above their width, so a signed 16-bit result fills only bits 15:0.

Top module: `fp_to_int_unit`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next clock edge, together with that request's result and flags. A cycle without a request drives `out_valid` low and holds the previous result. Reset clears `out_valid`, `result`, `illegal` and all flags.
- R2: `src_fmt` encodes 0 = half, 1 = single, 2 = double, and 3 is reserved. `dst_fmt[1:0]` encodes the width as 0 = 16, 1 = 32, 2 = 64, and 3 is reserved. `dst_fmt[2]` = 1 means signed. A half source with a 64-bit destination, a double source with a 16-bit destination, or any reserved code raises `illegal`, and the result and all flags are then 0.
- R3: Fields are decoded as half 1/5/10, single 1/8/23 and double 1/11/52 (sign/exponent/fraction), with exponent biases 15, 127 and 1023. Half uses `src_data[31:16]` when `half_hi` = 1 and `src_data[15:0]` otherwise. Single uses `src_data[31:0]`.
- R4: `rnd_mode` encodes 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, and 3 = toward zero. The integer produced is the exactly rounded value of the operand.
- R5: A rounded value above the destination maximum gives the maximum, and one below the minimum gives the minimum. Infinities clamp by their sign. A negative value that rounds to a nonzero integer gives 0 in an unsigned destination. Each of these cases sets `flag_sat`.
- R6: A NaN gives 0 unless the source is double or the destination is 64 bits. In that case it gives 0x8000_0000 for a 32-bit destination and 0x8000_0000_0000_0000 for a 64-bit destination. `flag_sat` is set for every NaN.
- R7: When `ftz` = 1, a single-precision denormal is treated as a zero of the same sign for 16- and 32-bit destinations. `ftz` has no effect on half or double sources or on 64-bit destinations, where denormals convert exactly.
- R8: A 16-bit result has `result[63:16]` = 0, and a 32-bit result has `result[63:32]` = 0.
- R9: `flag_zero` is set when the destination-width result is 0. `flag_neg` equals bit width-1 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request |
| src_data | input | 64 | Source operand word |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 3 | Destination signedness and width code |
| rnd_mode | input | 2 | Rounding mode |
| ftz | input | 1 | Flush single-precision denormals |
| half_hi | input | 1 | Take the half operand from bits 31:16 |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Converted integer, zero-extended |
| illegal | output | 1 | Unsupported format pair |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Top bit of the destination width |
| flag_sat | output | 1 | Clamped or NaN |

## Verification
The unit holds no state beyond one output register, so any internal fault shows at the ports one cycle after the request that triggers it. A wrong exponent alignment or round-bit position shows as a result that is off by one or off by a power of two. A wrong clamp limit shows only near the range edges or for infinities. A misrouted NaN or flush decision shows only for the matching format pair. The bench therefore steers random exponents to the edges of the destination range, and it adds directed operands at ties, denormals and the limits of each width.

// File: rtl/fti_pkg.sv
package fti_pkg;
    localparam int XLEN   = 64;
    localparam int MANT_W = 53;
    localparam int EXP_W  = 13;

    typedef enum logic [1:0] {
        SRC_HALF   = 2'd0,
        SRC_SINGLE = 2'd1,
        SRC_DOUBLE = 2'd2,
        SRC_RSVD   = 2'd3
    } src_fmt_e;

    typedef enum logic [1:0] {
        WID_16   = 2'd0,
        WID_32   = 2'd1,
        WID_64   = 2'd2,
        WID_RSVD = 2'd3
    } wid_e;

    typedef enum logic [1:0] {
        RND_NEAR  = 2'd0,
        RND_FLOOR = 2'd1,
        RND_CEIL  = 2'd2,
        RND_TRUNC = 2'd3
    } rnd_e;

    // value = mant * 2^(exp - (MANT_W-1))
    typedef struct packed {
        logic                    sign;
        logic                    nan;
        logic                    inf;
        logic                    zero;
        logic                    denorm;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
    } fp_unpk_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic            illegal;
        logic            zf;
        logic            nf;
        logic            sf;
    } conv_state_t;
endpackage

// File: rtl/fti_field_decode.sv
module fti_field_decode
    import fti_pkg::*;
#(
    parameter int EXP_BITS  = 8,
    parameter int FRAC_BITS = 23
) (
    input  logic [EXP_BITS+FRAC_BITS:0] bits_i,
    output fp_unpk_t                    unpk_o
);
    localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
    localparam int PAD  = MANT_W - 1 - FRAC_BITS;

    logic [EXP_BITS-1:0]  ef;
    logic [FRAC_BITS-1:0] fr;
    logic                 e_max;
    logic                 e_min;
    logic                 f_nz;

    assign ef = bits_i[EXP_BITS+FRAC_BITS-1:FRAC_BITS];
    assign fr = bits_i[FRAC_BITS-1:0];

    always_comb begin
        e_max         = &ef;
        e_min         = ~|ef;
        f_nz          = |fr;
        unpk_o.sign   = bits_i[EXP_BITS+FRAC_BITS];
        unpk_o.nan    = e_max & f_nz;
        unpk_o.inf    = e_max & ~f_nz;
        unpk_o.zero   = e_min & ~f_nz;
        unpk_o.denorm = e_min & f_nz;
        // denormals share the smallest normal exponent, hidden bit cleared
        unpk_o.exp    = e_min ? EXP_W'(1 - BIAS) : EXP_W'(32'(ef) - BIAS);
        unpk_o.mant   = MANT_W'({~e_min, fr}) << PAD;
    end
endmodule

// File: rtl/fti_round_int.sv
module fti_round_int
    import fti_pkg::*;
#(
    parameter int OUT_W = 64
) (
    input  fp_unpk_t       unpk_i,
    input  logic [1:0]     rnd_i,
    output logic [OUT_W:0] mag_o,
    output logic           big_o
);
    localparam int FB  = MANT_W - 1;
    localparam int SHW = $clog2(MANT_W + 1) + 1;

    int                 e_int;
    logic [SHW-1:0]     sh;
    logic [MANT_W:0]    ext;
    logic [MANT_W:0]    low_mask;
    logic [OUT_W-1:0]   int_part;
    logic               rbit;
    logic               sticky;
    logic               inc;

    always_comb begin
        e_int    = int'($signed(unpk_i.exp));
        int_part = '0;
        rbit     = 1'b0;
        sticky   = 1'b0;
        big_o    = 1'b0;
        sh       = '0;
        ext      = {unpk_i.mant, 1'b0};
        low_mask = '0;
        if (!unpk_i.zero) begin
            if (e_int >= OUT_W) begin
                big_o = 1'b1;
            end else if (e_int > FB) begin
                int_part = OUT_W'(unpk_i.mant) << (e_int - FB);
            end else if (e_int >= -1) begin
                sh       = SHW'(FB - e_int);
                int_part = OUT_W'(unpk_i.mant >> sh);
                ext      = {unpk_i.mant, 1'b0} >> sh;
                rbit     = ext[0];
                low_mask = ((MANT_W + 1)'(1) << sh) - 1'b1;
                sticky   = |({unpk_i.mant, 1'b0} & low_mask);
            end else begin
                sticky = |unpk_i.mant;
            end
        end
        unique case (rnd_e'(rnd_i))
            RND_NEAR:  inc = rbit & (sticky | int_part[0]);
            RND_FLOOR: inc = unpk_i.sign & (rbit | sticky);
            RND_CEIL:  inc = ~unpk_i.sign & (rbit | sticky);
            default:   inc = 1'b0;
        endcase
        mag_o = {1'b0, int_part} + (OUT_W + 1)'(inc);
    end
endmodule

// File: rtl/fti_saturate.sv
module fti_saturate #(
    parameter int OUT_W = 64
) (
    input  logic             sign_i,
    input  logic             nan_i,
    input  logic             inf_i,
    input  logic             big_i,
    input  logic [OUT_W:0]   mag_i,
    input  logic [1:0]       wcode_i,
    input  logic             signed_i,
    input  logic             src_dbl_i,
    output logic [OUT_W-1:0] res_o,
    output logic             sat_o
);
    int               w;
    logic [OUT_W:0]   pos_lim;
    logic [OUT_W:0]   neg_lim;
    logic [OUT_W:0]   neg_val;
    logic [OUT_W-1:0] wmask;
    logic [OUT_W-1:0] raw;

    always_comb begin
        unique case (wcode_i)
            2'd0:    w = 16;
            2'd1:    w = 32;
            default: w = OUT_W;
        endcase
        pos_lim = signed_i ? ((OUT_W + 1)'(1) << (w - 1)) - 1'b1
                           : ((OUT_W + 1)'(1) << w) - 1'b1;
        neg_lim = (OUT_W + 1)'(1) << (w - 1);
        wmask   = (w >= OUT_W) ? '1 : (OUT_W'(1) << w) - 1'b1;
        neg_val = '0;
        raw     = '0;
        sat_o   = 1'b0;
        if (nan_i) begin
            sat_o = 1'b1;
            if (src_dbl_i || w == OUT_W) raw = OUT_W'(1) << (w - 1);
        end else if (!sign_i) begin
            if (inf_i || big_i || mag_i > pos_lim) begin
                raw   = pos_lim[OUT_W-1:0];
                sat_o = 1'b1;
            end else begin
                raw = mag_i[OUT_W-1:0];
            end
        end else if (!signed_i) begin
            if (inf_i || big_i || mag_i != '0) sat_o = 1'b1;
        end else begin
            if (inf_i || big_i || mag_i > neg_lim) begin
                neg_val = '0 - neg_lim;
                sat_o   = 1'b1;
            end else begin
                neg_val = '0 - mag_i;
            end
            raw = neg_val[OUT_W-1:0];
        end
        res_o = raw & wmask;
    end
endmodule

// File: rtl/fp_to_int_unit.sv
module fp_to_int_unit
    import fti_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src_data,
    input  logic [1:0]      src_fmt,
    input  logic [2:0]      dst_fmt,
    input  logic [1:0]      rnd_mode,
    input  logic            ftz,
    input  logic            half_hi,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal,
    output logic            flag_zero,
    output logic            flag_neg,
    output logic            flag_sat
);
    conv_state_t    st_d;
    conv_state_t    st_q;

    logic [15:0]    half_op;
    fp_unpk_t       unpk_h;
    fp_unpk_t       unpk_s;
    fp_unpk_t       unpk_d;
    fp_unpk_t       unpk_sel;
    logic [1:0]     wcode;
    logic           bad_pair;
    logic [XLEN:0]  mag;
    logic           big;
    logic [XLEN-1:0] sat_res;
    logic           sat_flag;
    logic           neg_bit;

    assign half_op = half_hi ? src_data[31:16] : src_data[15:0];
    assign wcode   = dst_fmt[1:0];

    fti_field_decode #(.EXP_BITS(5),  .FRAC_BITS(10)) u_dec_half   (.bits_i(half_op),        .unpk_o(unpk_h));
    fti_field_decode #(.EXP_BITS(8),  .FRAC_BITS(23)) u_dec_single (.bits_i(src_data[31:0]), .unpk_o(unpk_s));
    fti_field_decode #(.EXP_BITS(11), .FRAC_BITS(52)) u_dec_double (.bits_i(src_data),       .unpk_o(unpk_d));

    always_comb begin
        bad_pair = (src_fmt == SRC_RSVD) || (wcode == WID_RSVD)
                || (src_fmt == SRC_HALF && wcode == WID_64)
                || (src_fmt == SRC_DOUBLE && wcode == WID_16);
        unique case (src_fmt)
            SRC_HALF:   unpk_sel = unpk_h;
            SRC_SINGLE: unpk_sel = unpk_s;
            default:    unpk_sel = unpk_d;
        endcase
        // flush applies to single sources headed for narrow targets only
        if (ftz && src_fmt == SRC_SINGLE && wcode != WID_64 && unpk_s.denorm) begin
            unpk_sel.zero   = 1'b1;
            unpk_sel.denorm = 1'b0;
            unpk_sel.mant   = '0;
        end
    end

    fti_round_int #(.OUT_W(XLEN)) u_round (
        .unpk_i (unpk_sel),
        .rnd_i  (rnd_mode),
        .mag_o  (mag),
        .big_o  (big)
    );

    fti_saturate #(.OUT_W(XLEN)) u_sat (
        .sign_i    (unpk_sel.sign),
        .nan_i     (unpk_sel.nan),
        .inf_i     (unpk_sel.inf),
        .big_i     (big),
        .mag_i     (mag),
        .wcode_i   (wcode),
        .signed_i  (dst_fmt[2]),
        .src_dbl_i (src_fmt == SRC_DOUBLE),
        .res_o     (sat_res),
        .sat_o     (sat_flag)
    );

    always_comb begin
        unique case (wcode)
            2'd0:    neg_bit = sat_res[15];
            2'd1:    neg_bit = sat_res[31];
            default: neg_bit = sat_res[XLEN-1];
        endcase
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = bad_pair;
            if (bad_pair) begin
                st_d.result = '0;
                st_d.zf     = 1'b0;
                st_d.nf     = 1'b0;
                st_d.sf     = 1'b0;
            end else begin
                st_d.result = sat_res;
                st_d.zf     = (sat_res == '0);
                st_d.nf     = neg_bit;
                st_d.sf     = sat_flag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign illegal   = st_q.illegal;
    assign flag_zero = st_q.zf;
    assign flag_neg  = st_q.nf;
    assign flag_sat  = st_q.sf;
endmodule

// File: rtl/fti_conv_checker.sv
module fti_conv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] src_data,
    input logic [1:0]  src_fmt,
    input logic [2:0]  dst_fmt,
    input logic [1:0]  rnd_mode,
    input logic        ftz,
    input logic        half_hi,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        illegal,
    input logic        flag_zero,
    input logic        flag_neg,
    input logic        flag_sat
);
    logic [1:0]  wc;
    logic        legal;
    logic        bad_combo;
    logic [15:0] hv;
    logic        s_neg;
    logic        s_nan;
    logic        s_zero;

    assign wc        = dst_fmt[1:0];
    assign bad_combo = (src_fmt == 2'd0 && wc == 2'd2) || (src_fmt == 2'd2 && wc == 2'd0);
    assign legal     = src_fmt != 2'd3 && wc != 2'd3 && !bad_combo;

    always_comb begin
        hv = half_hi ? src_data[31:16] : src_data[15:0];
        case (src_fmt)
            2'd0: begin
                s_neg  = hv[15];
                s_nan  = (&hv[14:10]) && (|hv[9:0]);
                s_zero = hv[14:0] == '0;
            end
            2'd1: begin
                s_neg  = src_data[31];
                s_nan  = (&src_data[30:23]) && (|src_data[22:0]);
                s_zero = src_data[30:0] == '0;
            end
            default: begin
                s_neg  = src_data[63];
                s_nan  = (&src_data[62:52]) && (|src_data[51:0]);
                s_zero = src_data[62:0] == '0;
            end
        endcase
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R2
    bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && bad_combo |=> illegal && result == '0 && !flag_sat);

    // R8
    narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && wc == 2'd0 |=> result[63:16] == '0);

    // R5
    neg_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && !dst_fmt[2] && s_neg && !s_nan |=> result == '0);

    // R9
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && s_zero |=> result == '0 && flag_zero && !flag_sat);

    // R6
    nan_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && s_nan && wc == 2'd0 |=> result == '0 && flag_sat);
endmodule

bind fp_to_int_unit fti_conv_checker u_chk (.*);

// File: tb/tb_fp_to_int_unit.sv
module tb_fp_to_int_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic [1:0]  src_fmt = '0;
    logic [2:0]  dst_fmt = '0;
    logic [1:0]  rnd_mode = '0;
    logic        ftz = 1'b0;
    logic        half_hi = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;
    logic        flag_zero;
    logic        flag_neg;
    logic        flag_sat;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fp_to_int_unit dut (.*);

    // reference: value computed in real arithmetic, then rounded and clamped
    function automatic void ref_model(input logic [63:0] s, input logic [1:0] sf, input logic [2:0] df,
                                      input logic [1:0] rm, input logic fz, input logic hh,
                                      output logic [63:0] r, output logic il, output logic z,
                                      output logic n, output logic st);
        int w, ei;
        longint fi;
        logic sg, isnan, isinf, sgn_dst;
        logic [15:0] h;
        logic [63:0] mask, hi_bits, lo_bits;
        real v, fl, fr, rr, hi_b, lo_b;
        il = sf == 2'd3 || df[1:0] == 2'd3 || (sf == 2'd0 && df[1:0] == 2'd2) || (sf == 2'd2 && df[1:0] == 2'd0);
        r = '0; z = 1'b0; n = 1'b0; st = 1'b0;
        if (il) return;
        w = 16 << df[1:0];
        sgn_dst = df[2];
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        case (sf)
            2'd0: begin
                h = hh ? s[31:16] : s[15:0];
                sg = h[15]; ei = int'(h[14:10]); fi = longint'(h[9:0]);
                isnan = ei == 31 && fi != 0; isinf = ei == 31 && fi == 0;
                v = (ei == 0) ? real'(fi) * 2.0**(-24) : real'(fi + 1024) * 2.0**(ei - 25);
            end
            2'd1: begin
                sg = s[31]; ei = int'(s[30:23]); fi = longint'(s[22:0]);
                isnan = ei == 255 && fi != 0; isinf = ei == 255 && fi == 0;
                v = (ei == 0) ? real'(fi) * 2.0**(-149) : real'(fi + 64'd8388608) * 2.0**(ei - 150);
                if (ei == 0 && fz && w != 64) v = 0.0;
            end
            default: begin
                sg = s[63]; ei = int'(s[62:52]);
                isnan = ei == 2047 && s[51:0] != 0; isinf = ei == 2047 && s[51:0] == 0;
                v = (ei == 2047) ? 0.0 : $bitstoreal({1'b0, s[62:0]});
            end
        endcase
        if (sg) v = -v;
        hi_bits = sgn_dst ? ((64'd1 << (w - 1)) - 64'd1) : mask;
        lo_bits = sgn_dst ? (64'd1 << (w - 1)) : 64'd0;
        if (isnan) begin
            st = 1'b1;
            if (sf == 2'd2 || w == 64) r = 64'd1 << (w - 1);
        end else if (isinf) begin
            st = 1'b1;
            r = sg ? lo_bits : hi_bits;
        end else begin
            fl = $floor(v);
            case (rm)
                2'd0: begin
                    fr = v - fl;
                    if (fr > 0.5) rr = fl + 1.0;
                    else if (fr < 0.5) rr = fl;
                    else rr = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
                end
                2'd1: rr = fl;
                2'd2: rr = $ceil(v);
                default: rr = (v >= 0.0) ? fl : $ceil(v);
            endcase
            hi_b = sgn_dst ? 2.0**(w - 1) : 2.0**w;
            lo_b = sgn_dst ? -(2.0**(w - 1)) : 0.0;
            if (rr >= hi_b) begin
                r = hi_bits; st = 1'b1;
            end else if (rr < lo_b) begin
                r = lo_bits; st = 1'b1;
            end else if (rr >= 2.0**63) begin
                r = 64'h8000_0000_0000_0000 + 64'(longint'(rr - 2.0**63));
            end else begin
                r = 64'(longint'(rr)) & mask;
            end
        end
        z = r == '0;
        n = r[w - 1];
    endfunction

    task automatic report(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (src=%h sf=%0d df=%0d rm=%0d ftz=%0b hh=%0b)",
                     req, act, exp_v, src_data, src_fmt, dst_fmt, rnd_mode, ftz, half_hi);
        end
    endtask

    task automatic convert(input logic [63:0] s, input logic [1:0] sf, input logic [2:0] df,
                           input logic [1:0] rm, input logic fz, input logic hh);
        logic [63:0] er;
        logic eil, ez, en, es;
        string tag;
        @(negedge clk);
        src_data = s; src_fmt = sf; dst_fmt = df; rnd_mode = rm; ftz = fz; half_hi = hh;
        in_valid = 1'b1;
        ref_model(s, sf, df, rm, fz, hh, er, eil, ez, en, es);
        @(negedge clk);
        in_valid = 1'b0;
        if (eil) tag = "R2";
        else if (es) tag = "R5/R6";
        else tag = "R4";
        report("R1 valid", {63'd0, out_valid}, 64'd1);
        report({tag, " result"}, result, er);
        report("R2 illegal", {63'd0, illegal}, {63'd0, eil});
        report("R9 flags", {61'd0, flag_zero, flag_neg, flag_sat}, {61'd0, ez, en, es});
    endtask

    function automatic logic [63:0] rand_src(input logic [1:0] sf);
        logic [63:0] s;
        int pick;
        s = {$urandom, $urandom};
        pick = int'($urandom % 8);
        case (sf)
            2'd0: begin
                if (pick == 0) s[14:10] = 5'd0;
                if (pick == 1) s[30:26] = 5'd31;
            end
            2'd1: begin
                if (pick == 0) s[30:23] = 8'd0;
                else if (pick == 1) s[30:23] = 8'd255;
                else if (pick < 7) s[30:23] = 8'(110 + $urandom % 80);
            end
            default: begin
                if (pick == 0) s[62:52] = 11'd0;
                else if (pick == 1) s[62:52] = 11'd2047;
                else if (pick < 7) s[62:52] = 11'(1005 + $urandom % 85);
            end
        endcase
        return s;
    endfunction

    task automatic expect_lit(input string req, input logic [63:0] exp_v);
        report(req, result, exp_v);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        report("R1 reset valid", {63'd0, out_valid}, 64'd0);
        report("R1 reset result", result, 64'd0);
        report("R1 reset flags", {60'd0, illegal, flag_zero, flag_neg, flag_sat}, 64'd0);

        // R4 rounding, ties to even
        convert(64'h4020_0000, 2'd1, 3'b101, 2'd0, 1'b0, 1'b0); expect_lit("R4 2.5 nearest", 64'd2);
        convert(64'h4060_0000, 2'd1, 3'b101, 2'd0, 1'b0, 1'b0); expect_lit("R4 3.5 nearest", 64'd4);
        convert(64'hc020_0000, 2'd1, 3'b101, 2'd0, 1'b0, 1'b0); expect_lit("R4 -2.5 nearest", 64'h0000_0000_ffff_fffe);
        convert(64'hbfc0_0000, 2'd1, 3'b110, 2'd1, 1'b0, 1'b0); expect_lit("R4 -1.5 floor", 64'hffff_ffff_ffff_fffe);
        convert(64'h3f99_999a, 2'd1, 3'b001, 2'd2, 1'b0, 1'b0); expect_lit("R4 1.2 ceil", 64'd2);
        convert(64'hbfd9_999a, 2'd1, 3'b101, 2'd3, 1'b0, 1'b0); expect_lit("R4 -1.7 trunc", 64'h0000_0000_ffff_ffff);
        // R5 clamping
        convert(64'h5015_02f9, 2'd1, 3'b101, 2'd0, 1'b0, 1'b0); expect_lit("R5 1e10 S32", 64'h7fff_ffff);
        convert(64'hbf80_0000, 2'd1, 3'b001, 2'd0, 1'b0, 1'b0); expect_lit("R5 -1 U32", 64'd0);
        convert(64'h7ff0_0000_0000_0000, 2'd2, 3'b110, 2'd0, 1'b0, 1'b0); expect_lit("R5 +inf S64", 64'h7fff_ffff_ffff_ffff);
        convert(64'hff80_0000, 2'd1, 3'b100, 2'd0, 1'b0, 1'b0); expect_lit("R5 -inf S16", 64'h8000);
        convert(64'h43e0_0000_0000_0000, 2'd2, 3'b010, 2'd0, 1'b0, 1'b0); expect_lit("R5 2^63 U64", 64'h8000_0000_0000_0000);
        convert(64'h43e0_0000_0000_0000, 2'd2, 3'b110, 2'd0, 1'b0, 1'b0); expect_lit("R5 2^63 S64", 64'h7fff_ffff_ffff_ffff);
        // R6 NaN patterns
        convert(64'h7fc0_0000, 2'd1, 3'b101, 2'd0, 1'b0, 1'b0); expect_lit("R6 NaN single S32", 64'd0);
        convert(64'h7ff8_0000_0000_0000, 2'd2, 3'b001, 2'd0, 1'b0, 1'b0); expect_lit("R6 NaN double U32", 64'h8000_0000);
        convert(64'h7fc0_0000, 2'd1, 3'b110, 2'd0, 1'b0, 1'b0); expect_lit("R6 NaN single S64", 64'h8000_0000_0000_0000);
        // R3 half select
        convert(64'h4500_3c00, 2'd0, 3'b000, 2'd0, 1'b0, 1'b1); expect_lit("R3 half high", 64'd5);
        convert(64'h4500_3c00, 2'd0, 3'b000, 2'd0, 1'b0, 1'b0); expect_lit("R3 half low", 64'd1);
        // R7 flush only where it applies
        convert(64'h0000_0001, 2'd1, 3'b001, 2'd2, 1'b1, 1'b0); expect_lit("R7 ftz single U32", 64'd0);
        convert(64'h0000_0001, 2'd1, 3'b001, 2'd2, 1'b0, 1'b0); expect_lit("R7 no ftz single", 64'd1);
        convert(64'h0000_0001, 2'd1, 3'b010, 2'd2, 1'b1, 1'b0); expect_lit("R7 ftz ignored U64", 64'd1);
        convert(64'h0000_0001, 2'd0, 3'b100, 2'd2, 1'b1, 1'b0); expect_lit("R7 half denorm", 64'd1);
        convert(64'h0000_0000_0000_0001, 2'd2, 3'b001, 2'd2, 1'b1, 1'b0); expect_lit("R7 double denorm", 64'd1);
        // R8 / R9 narrow signed
        convert(64'hbf80_0000, 2'd1, 3'b100, 2'd0, 1'b0, 1'b0); expect_lit("R8 S16 -1", 64'h0000_0000_0000_ffff);
        report("R9 neg flag", {63'd0, flag_neg}, 64'd1);
        // R2 rejected pairs
        convert(64'h3c00, 2'd0, 3'b010, 2'd0, 1'b0, 1'b0); expect_lit("R2 half to U64", 64'd0);
        convert(64'h3ff0_0000_0000_0000, 2'd2, 3'b100, 2'd0, 1'b0, 1'b0); expect_lit("R2 double to S16", 64'd0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] sf;
            logic [2:0] df;
            sf = ($urandom % 20 == 0) ? 2'd3 : 2'($urandom % 3);
            df = 3'($urandom % 8);
            if (df[1:0] == 2'd3 && ($urandom % 4 != 0)) df[1:0] = 2'($urandom % 3);
            convert(rand_src(sf), sf, df, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
        end

        // R1 idle cycle drops valid and holds the result
        @(negedge clk);
        report("R1 idle valid", {63'd0, out_valid}, 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule